// File: doc/BRIEF.md
# Record FIFO with Format Conversion

This block is the capture-side sample queue between a producer of audio samples and a host reader. The producer pushes one 16-bit entry per sample. The host then reads the queue in one of four ways, chosen by a two-bit sample type and a host-width bit. It can read 8-bit or 16-bit samples, and each can be delivered over a byte-wide or a word-wide host path. Samples are stored in signed two's complement. An unsigned option turns them into offset-binary on the way out by inverting the top bit of each sample.

Two error conditions latch into sticky flags: a push into a full queue and a read that finds too few entries. Both are merged into one error bit and a maskable interrupt. A status write clears the flags and holds them clear, and a second status write re-arms them. While the enable input is low, the queue is held empty with all condition flags cleared. The depth is a parameter of at least 2.

Top module: `rec_fifo_fmt`

## Requirements
- R1: While rst_n is low, or while fifo_en is low at a clock edge, the block becomes empty: level 0, rd_data 0, ovf, unf, err and irq all 0.
- R2: A push with fifo_en high and the queue not full stores push_data and raises level by one. Entries leave in the order they arrived.
- R3: With dtype[0]=1 (16-bit samples) and wide=1, rd_data is the oldest entry with bit 15 inverted when uns_out=1. Each pop removes one entry.
- R4: With dtype[0]=0 (8-bit samples) and wide=0, rd_data[7:0] is the low byte of the oldest entry with bit 7 inverted when uns_out=1. rd_data[15:8] is 0, and each pop removes one entry.
- R5: With dtype[0]=1 and wide=0, the first read returns the low byte of the oldest entry, unchanged. After one pop, rd_data[7:0] shows its high byte with bit 7 inverted when uns_out=1. The entry is removed only by the pop of the high byte.
- R6: With dtype[0]=0 and wide=1, rd_data[7:0] is the low byte of the oldest entry and rd_data[15:8] is the low byte of the next one. Each byte has bit 7 inverted when uns_out=1, and a pop removes both entries.
- R7: A push while level equals DEPTH changes neither the stored data nor level, and sets ovf unless the flags are held.
- R8: A pop while level is below what the mode needs (2 for the R6 mode, 1 otherwise) changes neither the data nor level, and sets unf unless the flags are held.
- R9: A cycle with stat_wr=1 and stat_clr=1 clears ovf and unf and holds them clear. A later cycle with stat_wr=1 and stat_clr=0 lets them set again.
- R10: err is ovf OR unf; irq is err AND irq_en.
- R11: dtype[1] is ignored: dtype 2 behaves as 0 and dtype 3 as 1.
- R12: rd_data is 0 whenever level is below what the current mode needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| fifo_en | input | 1 | Queue enable; low holds the queue empty |
| dtype | input | 2 | Sample type: bit 0 selects 16-bit (1) or 8-bit (0) samples |
| wide | input | 1 | Host width: 1 = 16-bit words, 0 = bytes |
| uns_out | input | 1 | Invert the top bit of each sample on output |
| irq_en | input | 1 | Interrupt enable for the error bit |
| push | input | 1 | Producer writes push_data this cycle |
| push_data | input | 16 | Sample from the producer |
| pop | input | 1 | Host consumes the current rd_data |
| stat_wr | input | 1 | Status write strobe |
| stat_clr | input | 1 | Status write value: 1 clears and holds the flags, 0 re-arms them |
| rd_data | output | 16 | Formatted read value for the host |
| level | output | $clog2(DEPTH+1) | Number of stored entries |
| full | output | 1 | level equals DEPTH |
| empty | output | 1 | level is 0 |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |
| err | output | 1 | Combined error bit |
| irq | output | 1 | Error interrupt |

## Verification
The assertions assume that a status write does not fall in the same cycle as the error event it would affect. They also assume that the sample type and width are changed only while the queue is idle, never between the two halves of a split word. The stimulus follows both rules: it issues status writes in cycles of their own. It reconfigures the mode only after clearing the queue by dropping fifo_en, or when no byte phase is pending. Pushes and pops are driven one per cycle and never together, so each level change can be traced to a single cause.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int SAMPLE_W = 16;

  // Offset-binary conversion of one byte: top bit inverted when u is set.
  function automatic logic [7:0] flip_byte(input logic [7:0] b, input logic u);
    return {b[7] ^ u, b[6:0]};
  endfunction

  // Offset-binary conversion of one word: bit 15 inverted when u is set.
  function automatic logic [15:0] flip_word(input logic [15:0] w, input logic u);
    return {w[15] ^ u, w[14:0]};
  endfunction

  // Entries that one host read consumes when enough are present.
  function automatic int unsigned need_entries(input logic t16, input logic wd);
    return (!t16 && wd) ? 2 : 1;
  endfunction
endpackage

// File: rtl/rf_store.sv
module rf_store #(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         wr_en,
  input  logic [rf_pkg::SAMPLE_W-1:0]  wr_data,
  input  logic [1:0]                   rd_cnt,
  output logic [rf_pkg::SAMPLE_W-1:0]  head0,
  output logic [rf_pkg::SAMPLE_W-1:0]  head1,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [rf_pkg::SAMPLE_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p, input int n);
    int t;
    t = int'(p) + n;
    if (t >= DEPTH) t = t - DEPTH;
    return AW'(t);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else if (clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (wr_en) wp_q <= adv(wp_q, 1);
      rp_q  <= adv(rp_q, int'(rd_cnt));
      lvl_q <= lvl_q + LW'(wr_en) - LW'(rd_cnt);
    end
  end

  assign head0 = mem[rp_q];
  assign head1 = mem[adv(rp_q, 1)];
  assign level = lvl_q;
endmodule

// File: rtl/rf_unpack.sv
module rf_unpack #(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic [1:0]                   dtype,
  input  logic                         wide,
  input  logic                         uns,
  input  logic                         pop,
  input  logic [rf_pkg::SAMPLE_W-1:0]  head0,
  input  logic [rf_pkg::SAMPLE_W-1:0]  head1,
  input  logic [$clog2(DEPTH+1)-1:0]   level,
  output logic [rf_pkg::SAMPLE_W-1:0]  rd_data,
  output logic [1:0]                   pop_n,
  output logic                         unf_evt
);
  import rf_pkg::*;
  localparam int LW = $clog2(DEPTH+1);

  logic t16, split, pair, enough, phase_q;

  assign t16    = dtype[0];
  assign split  = t16 & ~wide;
  assign pair   = ~t16 & wide;
  assign enough = (int'(level) >= int'(need_entries(t16, wide)));

  always_comb begin
    rd_data = '0;
    if (enough) begin
      if (pair)       rd_data = {flip_byte(head1[7:0], uns), flip_byte(head0[7:0], uns)};
      else if (split) rd_data = {8'h00, phase_q ? flip_byte(head0[15:8], uns) : head0[7:0]};
      else if (t16)   rd_data = flip_word(head0, uns);
      else            rd_data = {8'h00, flip_byte(head0[7:0], uns)};
    end
  end

  always_comb begin
    pop_n = 2'd0;
    if (pop && enough) begin
      if (pair)       pop_n = 2'd2;
      else if (split) pop_n = phase_q ? 2'd1 : 2'd0;
      else            pop_n = 2'd1;
    end
  end

  assign unf_evt = pop & ~enough;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase_q <= 1'b0;
    else if (clr || !split)    phase_q <= 1'b0;
    else if (pop && enough)    phase_q <= ~phase_q;
  end
endmodule

// File: rtl/rf_errflags.sv
module rf_errflags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ovf_evt,
  input  logic unf_evt,
  input  logic stat_wr,
  input  logic stat_clr,
  output logic ovf,
  output logic unf,
  output logic hold
);
  logic hold_q, ovf_q, unf_q, wipe;

  assign wipe = clr | (stat_wr & stat_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= 1'b0;
    else if (stat_wr) hold_q <= stat_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (wipe) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (!hold_q) begin
      if (ovf_evt) ovf_q <= 1'b1;
      if (unf_evt) unf_q <= 1'b1;
    end
  end

  assign ovf  = ovf_q;
  assign unf  = unf_q;
  assign hold = hold_q;
endmodule

// File: rtl/rec_fifo_fmt.sv
module rec_fifo_fmt #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fifo_en,
  input  logic [1:0]                 dtype,
  input  logic                       wide,
  input  logic                       uns_out,
  input  logic                       irq_en,
  input  logic                       push,
  input  logic [15:0]                push_data,
  input  logic                       pop,
  input  logic                       stat_wr,
  input  logic                       stat_clr,
  output logic [15:0]                rd_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty,
  output logic                       ovf,
  output logic                       unf,
  output logic                       err,
  output logic                       irq
);
  localparam int LW = $clog2(DEPTH+1);

  logic        q_clr;
  logic        wr_acc;
  logic        ovf_evt;
  logic        unf_raw;
  logic        unf_evt;
  logic        pop_g;
  logic [1:0]  pop_n;
  logic        err_hold;
  logic [15:0] head0, head1;
  logic [LW-1:0] lvl;

  assign q_clr   = ~fifo_en;
  assign full    = (int'(lvl) == DEPTH);
  assign empty   = (lvl == '0);
  assign wr_acc  = fifo_en & push & ~full;
  assign ovf_evt = fifo_en & push & full;
  assign pop_g   = fifo_en & pop;
  assign unf_evt = fifo_en & unf_raw;

  rf_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (q_clr),
    .wr_en   (wr_acc),
    .wr_data (push_data),
    .rd_cnt  (pop_n),
    .head0   (head0),
    .head1   (head1),
    .level   (lvl)
  );

  rf_unpack #(.DEPTH(DEPTH)) u_unpack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (q_clr),
    .dtype   (dtype),
    .wide    (wide),
    .uns     (uns_out),
    .pop     (pop_g),
    .head0   (head0),
    .head1   (head1),
    .level   (lvl),
    .rd_data (rd_data),
    .pop_n   (pop_n),
    .unf_evt (unf_raw)
  );

  rf_errflags u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (q_clr),
    .ovf_evt  (ovf_evt),
    .unf_evt  (unf_evt),
    .stat_wr  (stat_wr),
    .stat_clr (stat_clr),
    .ovf      (ovf),
    .unf      (unf),
    .hold     (err_hold)
  );

  assign level = lvl;
  assign err   = ovf | unf;
  assign irq   = err & irq_en;
endmodule

// File: rtl/rf_chk.sv
module rf_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fifo_en,
  input logic                       push,
  input logic                       pop,
  input logic                       stat_wr,
  input logic                       stat_clr,
  input logic                       irq_en,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic                       full,
  input logic                       ovf,
  input logic                       unf,
  input logic                       irq,
  input logic                       ovf_evt,
  input logic                       unf_evt,
  input logic                       err_hold,
  input logic [1:0]                 pop_n
);
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> (level == '0 && !ovf && !unf)); // R1
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH); // R2
  AST_POP_WITHIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_n) <= int'(level)); // R6
  AST_FULL_PUSH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && push && full && !pop) |=> $stable(level)); // R7
  AST_OVF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && ovf_evt && !err_hold && !stat_wr) |=> ovf); // R7
  AST_SHORT_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && unf_evt && !push) |=> $stable(level)); // R8
  AST_UNF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && unf_evt && !err_hold && !stat_wr) |=> unf); // R8
  AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_clr) |=> (!ovf && !unf)); // R9
  AST_HELD_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_hold && !ovf && !unf && !stat_wr) |=> (!ovf && !unf)); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && (ovf || unf))); // R10
endmodule

bind rec_fifo_fmt rf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fifo_en  (fifo_en),
  .push     (push),
  .pop      (pop),
  .stat_wr  (stat_wr),
  .stat_clr (stat_clr),
  .irq_en   (irq_en),
  .level    (level),
  .full     (full),
  .ovf      (ovf),
  .unf      (unf),
  .irq      (irq),
  .ovf_evt  (ovf_evt),
  .unf_evt  (unf_evt),
  .err_hold (err_hold),
  .pop_n    (pop_n)
);

// File: tb/rec_fifo_fmt_tb.sv
module rec_fifo_fmt_tb;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH+1);
  localparam int NV = 10;

  // {dtype, wide, uns, w0, w1, first read, read after one pop}
  localparam logic [67:0] VEC [NV] = '{
    {2'b01, 1'b1, 1'b0, 16'h8134, 16'h7F02, 16'h8134, 16'h7F02},
    {2'b01, 1'b1, 1'b1, 16'h8134, 16'h7F02, 16'h0134, 16'hFF02},
    {2'b00, 1'b0, 1'b0, 16'h8134, 16'h7F02, 16'h0034, 16'h0002},
    {2'b00, 1'b0, 1'b1, 16'h8134, 16'h7F02, 16'h00B4, 16'h0082},
    {2'b01, 1'b0, 1'b0, 16'h8134, 16'h7F02, 16'h0034, 16'h0081},
    {2'b01, 1'b0, 1'b1, 16'h8134, 16'h7F02, 16'h0034, 16'h0001},
    {2'b00, 1'b1, 1'b0, 16'h8134, 16'h7F02, 16'h0234, 16'h0000},
    {2'b00, 1'b1, 1'b1, 16'h8134, 16'h7F02, 16'h82B4, 16'h0000},
    {2'b11, 1'b1, 1'b1, 16'h8134, 16'h7F02, 16'h0134, 16'hFF02},
    {2'b10, 1'b0, 1'b1, 16'h8134, 16'h7F02, 16'h00B4, 16'h0082}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0;
  logic [1:0] dtype = 2'b01;
  logic wide = 1'b1, uns_out = 1'b0, irq_en = 1'b0;
  logic push = 1'b0, pop = 1'b0, stat_wr = 1'b0, stat_clr = 1'b0;
  logic [15:0] push_data = '0;
  logic [15:0] rd_data;
  logic [LW-1:0] level;
  logic full, empty, ovf, unf, err, irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rec_fifo_fmt #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dtype(dtype), .wide(wide),
    .uns_out(uns_out), .irq_en(irq_en), .push(push), .push_data(push_data),
    .pop(pop), .stat_wr(stat_wr), .stat_clr(stat_clr), .rd_data(rd_data),
    .level(level), .full(full), .empty(empty), .ovf(ovf), .unf(unf),
    .err(err), .irq(irq)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_push(input logic [15:0] d);
    push = 1'b1; push_data = d;
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic do_pop();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic do_stat(input logic c);
    stat_wr = 1'b1; stat_clr = c;
    @(negedge clk);
    stat_wr = 1'b0; stat_clr = 1'b0;
  endtask

  task automatic requeue();
    fifo_en = 1'b0;
    @(negedge clk);
    fifo_en = 1'b1;
  endtask

  function automatic string req_of(input logic [1:0] t, input logic w);
    if (t[1]) return "R11";
    if (t[0] && w) return "R3";
    if (!t[0] && !w) return "R4";
    if (t[0]) return "R5";
    return "R6";
  endfunction

  function automatic int lvl_after(input logic [1:0] t, input logic w);
    if (!t[0] && w) return 0;
    if (t[0] && !w) return 2;
    return 1;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    chk(int'(level), 0, "R1", "level in reset");
    chk(int'(rd_data), 0, "R1", "rd_data in reset");
    chk(int'({ovf, unf, err, irq}), 0, "R1", "flags in reset");
    rst_n = 1'b1;
    @(negedge clk);
    fifo_en = 1'b1;
    @(negedge clk);

    // Table walk over format modes
    for (int i = 0; i < NV; i++) begin
      logic [67:0] v;
      v = VEC[i];
      requeue();
      dtype = v[67:66]; wide = v[65]; uns_out = v[64];
      do_push(v[63:48]);
      do_push(v[47:32]);
      chk(int'(rd_data), int'(v[31:16]), req_of(v[67:66], v[65]), "first read");
      do_pop();
      chk(int'(rd_data), int'(v[15:0]), req_of(v[67:66], v[65]), "read after pop");
      chk(int'(level), lvl_after(v[67:66], v[65]), req_of(v[67:66], v[65]), "level after pop");
    end

    // R2: ordering, 16-bit words
    requeue();
    dtype = 2'b01; wide = 1'b1; uns_out = 1'b0;
    do_push(16'h1111); do_push(16'h2222); do_push(16'h3333);
    chk(int'(level), 3, "R2", "level after three pushes");
    chk(int'(rd_data), 16'h1111, "R2", "oldest first");
    do_pop();
    chk(int'(rd_data), 16'h2222, "R2", "second entry");
    do_pop();
    chk(int'(rd_data), 16'h3333, "R2", "third entry");

    // R7: overflow on full
    requeue();
    for (int k = 0; k < DEPTH; k++) do_push(16'h0100 + 16'(k));
    chk(int'(full), 1, "R7", "full after filling");
    chk(int'(ovf), 0, "R7", "no ovf before extra push");
    do_push(16'hDEAD);
    chk(int'(level), DEPTH, "R7", "level unchanged by extra push");
    chk(int'(ovf), 1, "R7", "ovf set");
    chk(int'(rd_data), 16'h0100, "R7", "head data preserved");
    // R10: combined error and interrupt mask
    chk(int'(err), 1, "R10", "err follows ovf");
    chk(int'(irq), 0, "R10", "irq masked");
    irq_en = 1'b1;
    @(negedge clk);
    chk(int'(irq), 1, "R10", "irq enabled");

    // R9: clear/hold, then re-arm
    do_stat(1'b1);
    chk(int'({ovf, unf, irq}), 0, "R9", "cleared by status write");
    do_push(16'hBEEF);
    chk(int'(ovf), 0, "R9", "held clear during overflow");
    do_stat(1'b0);
    chk(int'(ovf), 0, "R9", "re-arm write does not set");
    do_push(16'hBEEF);
    chk(int'(ovf), 1, "R9", "sets again after re-arm");
    irq_en = 1'b0;

    // R1: enable low clears flags and contents
    requeue();
    chk(int'({level == '0, ovf, rd_data == 16'h0}), 3'b101, "R1", "disable clears");

    // R8: underflow on empty
    do_pop();
    chk(int'(unf), 1, "R8", "unf on empty pop");
    chk(int'(level), 0, "R8", "level stays 0");
    do_stat(1'b1);
    do_stat(1'b0);
    // R8 and R12: paired byte mode with only one entry
    dtype = 2'b00; wide = 1'b1; uns_out = 1'b0;
    do_push(16'h0055);
    chk(int'(rd_data), 0, "R12", "rd_data zero when short");
    do_pop();
    chk(int'(unf), 1, "R8", "unf on short pair read");
    chk(int'(level), 1, "R8", "entry kept after short read");
    wide = 1'b0;
    @(negedge clk);
    chk(int'(rd_data), 16'h0055, "R4", "kept entry readable as byte");
    chk(int'(empty), 0, "R4", "not empty");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule